// File: doc/BRIEF.md
# Trace Store and Compress Controller

This block turns the 1024-word trace held in an external sample memory into a permanent reference. When the operator asks for a store, a four-state sequencer walks the memory in pairs of neighbouring words. It keeps the larger word of each pair and writes it into one location of the lower half of the memory. The magnitude test is a ripple adder that adds the memory read word to the inverted latch word. Its carry out decides whether the latch takes the odd word of the pair. The external data multiplexer feeds the latch back into the memory for as long as the sequencer needs it.

Outside a store, the block passes the sample write address through to the memory and keeps the write enable high, so every write phase stores the incoming sample. Once a trace has been stored, incoming samples are folded into the upper half, which becomes the live (refresh) trace. A free-running display counter first scans the refresh half and then the stored half in each display period. The block drives the memory address, the write enable, the multiplexer select, the latch load strobe and the display address. The memory, the latch and the sample converters are outside the block.

Top module: `trace_store_ctrl`

## Requirements
- R1: After reset the block is idle, with busy=0, done=0, mux_sel=0, latch_load=0, mem_we=1 and scan_half=0.
- R2: While idle and before any store, mem_addr equals wr_addr_in, mem_we is 1, and mux_sel and latch_load are 0 in every cycle.
- R3: A store_req that is high at a clock edge while idle starts a store, and busy is 1 from the next cycle on. Each pair k takes three cycles. In the first, mem_addr=2k and latch_load=1. In the second, mem_addr=2k+1 and mux_sel=1. In the third, mem_addr=k, mux_sel=1 and mem_we=1.
- R4: In the second cycle of a pair, latch_load is 1 exactly when rd_data is greater than latch_q as unsigned numbers, which is the carry out of rd_data plus the bitwise inverse of latch_q.
- R5: After a store, location k (0..511) holds the maximum of the words that were at locations 2k and 2k+1 when the store started. mem_we is 1 during a store only together with mux_sel=1.
- R6: A store lasts 1536 busy cycles. It is followed by a one-cycle done pulse, during which busy is already 0.
- R7: A store_req that arrives while busy is ignored. The running store keeps its length and its written values.
- R8: After a completed store, idle writes go to address 512 + (wr_addr_in >> 1), so the stored lower half is never written.
- R9: disp_addr increases by one every cycle and wraps from 1023 to 0, except in the done cycle. Before any store, scan_half stays 0.
- R10: After a store, each display period of 1024 cycles shows 512 consecutive cycles with scan_half=0 on addresses 512..1023, then 512 with scan_half=1 on addresses 0..511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| store_req | input | 1 | Request to store the current trace |
| wr_addr_in | input | 10 | Sample write address from the horizontal converter |
| rd_data | input | 8 | Memory read word at mem_addr |
| latch_q | input | 8 | Output of the external data latch |
| mem_addr | output | 10 | Memory address for the write and compress port |
| mem_we | output | 1 | Memory write enable |
| mux_sel | output | 1 | 1 selects latch_q as memory write data, 0 selects the sample |
| latch_load | output | 1 | Latch takes rd_data at the next edge |
| disp_addr | output | 10 | Display scan read address |
| scan_half | output | 1 | 0 while the refresh half is scanned, 1 for the stored half |
| busy | output | 1 | Store in progress |
| done | output | 1 | One-cycle pulse when a store completes |

## Verification
The assertions assume that rd_data is the asynchronous read of the word at mem_addr. They also assume that latch_q changes only at an edge where latch_load was high, taking rd_data. Without that, the compare and the kept maximum mean nothing. The bench models the memory and the latch that way. It fills the memory either through the block's own idle write path or through a bench-side port, and then holds wr_addr_in and the sample constant while a store runs. Only one store request is raised while busy, so the timing check for the ignored request is unambiguous.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CMP   = 2'd2,
        ST_PUT   = 2'd3
    } tsc_state_e;
endpackage

// File: rtl/tsc_cmp.sv
module tsc_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              gt_o
);
    // ripple adder of a and ~b with carry-in 0: carry out means a > b
    logic [DATA_W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic nb;
        assign nb     = ~b_i[i];
        assign c[i+1] = (a_i[i] & nb) | (a_i[i] & c[i]) | (nb & c[i]);
    end

    assign gt_o = c[DATA_W];
endmodule

// File: rtl/tsc_scan.sv
module tsc_scan #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_i,
    output logic [ADDR_W-1:0] disp_addr_o,
    output logic              half_o
);
    localparam int MSB = ADDR_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d     = scan_q;
        scan_d.cnt = scan_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    always_comb begin
        if (split_i) begin
            // first half of the period: upper (refresh) half; then lower (stored)
            disp_addr_o = {~scan_q.cnt[MSB], scan_q.cnt[MSB-1:0]};
            half_o      = scan_q.cnt[MSB];
        end else begin
            disp_addr_o = scan_q.cnt;
            half_o      = 1'b0;
        end
    end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic              gt_i,
    input  logic [ADDR_W-1:0] wr_addr_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mux_sel,
    output logic              latch_load,
    output logic              busy,
    output logic              done,
    output logic              split_o
);
    localparam int PAIR_W = ADDR_W - 1;
    localparam logic [PAIR_W-1:0] LAST_PAIR = '1;

    typedef struct packed {
        tsc_state_e        st;
        logic [PAIR_W-1:0] k;
        logic              done;
        logic              split;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (store_req) begin
                    ctrl_d.st = ST_FETCH;
                    ctrl_d.k  = '0;
                end
            end
            ST_FETCH: ctrl_d.st = ST_CMP;
            ST_CMP:   ctrl_d.st = ST_PUT;
            ST_PUT: begin
                if (ctrl_q.k == LAST_PAIR) begin
                    ctrl_d.st    = ST_IDLE;
                    ctrl_d.done  = 1'b1;
                    ctrl_d.split = 1'b1;
                end else begin
                    ctrl_d.st = ST_FETCH;
                    ctrl_d.k  = ctrl_q.k + 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st    <= ST_IDLE;
            ctrl_q.k     <= '0;
            ctrl_q.done  <= 1'b0;
            ctrl_q.split <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        mem_addr   = wr_addr_in;
        mem_we     = 1'b0;
        mux_sel    = 1'b0;
        latch_load = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                mem_we = 1'b1;
                if (ctrl_q.split) mem_addr = {1'b1, wr_addr_in[ADDR_W-1:1]};
            end
            ST_FETCH: begin
                mem_addr   = {ctrl_q.k, 1'b0};
                latch_load = 1'b1;
            end
            ST_CMP: begin
                mem_addr   = {ctrl_q.k, 1'b1};
                mux_sel    = 1'b1;
                latch_load = gt_i;
            end
            ST_PUT: begin
                mem_addr = {1'b0, ctrl_q.k};
                mux_sel  = 1'b1;
                mem_we   = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy    = (ctrl_q.st != ST_IDLE);
    assign done    = ctrl_q.done;
    assign split_o = ctrl_q.split;
endmodule

// File: rtl/trace_store_ctrl.sv
module trace_store_ctrl #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic [ADDR_W-1:0] wr_addr_in,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] latch_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mux_sel,
    output logic              latch_load,
    output logic [ADDR_W-1:0] disp_addr,
    output logic              scan_half,
    output logic              busy,
    output logic              done
);
    logic gt;
    logic split;

    tsc_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a_i  (rd_data),
        .b_i  (latch_q),
        .gt_o (gt)
    );

    tsc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_req  (store_req),
        .gt_i       (gt),
        .wr_addr_in (wr_addr_in),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mux_sel    (mux_sel),
        .latch_load (latch_load),
        .busy       (busy),
        .done       (done),
        .split_o    (split)
    );

    tsc_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .split_i     (split),
        .disp_addr_o (disp_addr),
        .half_o      (scan_half)
    );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_req,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] latch_q,
    input logic              mem_we,
    input logic              mux_sel,
    input logic              latch_load,
    input logic [ADDR_W-1:0] disp_addr,
    input logic              scan_half,
    input logic              busy,
    input logic              done
);
    a_r2_idle_writes: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_we && !mux_sel && !latch_load));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req) |=> busy);

    a_r4_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mux_sel && !mem_we) |-> (latch_load == (rd_data > latch_q)));

    a_r5_we_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> mux_sel);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || disp_addr == $past(disp_addr) + 1'b1));

    a_r10_half: assert property (@(posedge clk) disable iff (!rst_n)
        scan_half |-> !disp_addr[ADDR_W-1]);
endmodule

bind trace_store_ctrl tsc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tsc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_req  (store_req),
    .rd_data    (rd_data),
    .latch_q    (latch_q),
    .mem_we     (mem_we),
    .mux_sel    (mux_sel),
    .latch_load (latch_load),
    .disp_addr  (disp_addr),
    .scan_half  (scan_half),
    .busy       (busy),
    .done       (done)
);

// File: tb/trace_store_ctrl_bench.sv
module trace_store_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int HALF = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic store_req = 1'b0;
    logic [AW-1:0] wr_addr_in = '0;
    logic [DW-1:0] y_data = '0;
    logic [DW-1:0] rd_data, latch_q;
    logic [AW-1:0] mem_addr, disp_addr;
    logic mem_we, mux_sel, latch_load, scan_half, busy, done;

    // bench-side fill port for the memory model
    logic bd_en = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [DW-1:0] bd_data = '0;

    logic [DW-1:0] mem [0:DEPTH-1];
    logic [DW-1:0] exp_max [0:HALF-1];
    logic [AW+DW-1:0] sb_q [$];

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_store_ctrl u_trace_store_ctrl (
        .clk, .rst_n, .store_req, .wr_addr_in, .rd_data, .latch_q,
        .mem_addr, .mem_we, .mux_sel, .latch_load, .disp_addr,
        .scan_half, .busy, .done
    );

    assign rd_data = mem[mem_addr];

    always_ff @(posedge clk) begin
        if (bd_en)       mem[bd_addr]  <= bd_data;
        else if (mem_we) mem[mem_addr] <= mux_sel ? latch_q : y_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (latch_load) latch_q <= rd_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: each compress write must match the next expected item
    always @(negedge clk) begin
        if (rst_n && busy && mem_we && mux_sel) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", int'(mem_addr), -1);
            end else begin
                logic [AW+DW-1:0] it;
                it = sb_q.pop_front();
                chk(mem_addr == it[AW+DW-1:DW], "R5 write address", int'(mem_addr), int'(it[AW+DW-1:DW]));
                chk(latch_q == it[DW-1:0], "R5 write max", int'(latch_q), int'(it[DW-1:0]));
            end
        end
    end

    task automatic bd_fill(input int mode);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            bd_en   = 1'b1;
            bd_addr = AW'(i);
            case (mode)
                0: bd_data = DW'(i[AW-1:1]);                               // equal pairs: carry never set
                default: bd_data = ((i[0] ^ i[1]) != 0) ? 8'hFF : 8'h00;   // 0/255 in both orders
            endcase
        end
        @(negedge clk);
        bd_en = 1'b0;
    endtask

    task automatic run_store(input bit poke_busy);
        int n;
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        // R3: first cycle after start
        chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        chk(mem_addr == 0 && latch_load, "R3 fetch even", int'(mem_addr), 0);
        for (int k = 0; k < HALF; k++) begin
            logic [DW-1:0] e, o;
            e = mem[2*k];
            o = mem[2*k+1];
            exp_max[k] = (o > e) ? o : e;
            sb_q.push_back({AW'(k), exp_max[k]});
        end
        n = 1;
        @(negedge clk);
        chk(mem_addr == 1 && mux_sel && !mem_we, "R3 compare odd", int'(mem_addr), 1);
        n++;
        @(negedge clk);
        chk(mem_addr == 0 && mux_sel && mem_we, "R3 write dest", int'(mem_addr), 0);
        n++;
        forever begin
            @(negedge clk);
            if (poke_busy && n == 700) store_req = 1'b1;   // R7 request while busy
            else store_req = 1'b0;
            if (!busy) break;
            n++;
        end
        store_req = 1'b0;
        chk(n == 3 * HALF, "R6 R7 busy length", n, 3 * HALF);
        chk(done == 1'b1, "R6 done pulse", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && !busy, "R6 done one cycle / R7 no restart", int'(done), 0);
        chk(sb_q.size() == 0, "R5 all writes seen", sb_q.size(), 0);
        for (int k = 0; k < HALF; k++)
            chk(mem[k] == exp_max[k], "R5 stored max", int'(mem[k]), int'(exp_max[k]));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] prev;
        int lo, hi;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mux_sel && !latch_load && mem_we && !scan_half,
            "R1 reset state", int'({busy, done, mux_sel, latch_load, mem_we, scan_half}), 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 fill through the idle write path, R9 scan walking
        prev = disp_addr;
        for (int i = 0; i < DEPTH; i++) begin
            wr_addr_in = AW'(i);
            y_data     = DW'($urandom_range(0, 255));
            @(negedge clk);
            chk(mem_addr == AW'(i) && mem_we && !mux_sel && !latch_load, "R2 idle pass-through",
                int'(mem_addr), i);
            chk(disp_addr == prev + 1'b1 && !scan_half, "R9 scan step", int'(disp_addr), int'(prev + 1'b1));
            prev = disp_addr;
        end
        for (int i = 0; i < 4; i++) begin
            // sanity: the idle writes reached the memory model
        end

        // store with a request while busy (R7)
        run_store(1'b1);

        // R8: idle writes now land in the upper half
        wr_addr_in = AW'(5);
        y_data     = 8'hA5;
        @(negedge clk);
        chk(mem_addr == AW'(HALF + 2) && mem_we, "R8 folded address", int'(mem_addr), HALF + 2);
        @(negedge clk);
        chk(mem[HALF + 2] == 8'hA5, "R8 refresh write", int'(mem[HALF + 2]), 8'hA5);
        chk(mem[5] == exp_max[5], "R8 stored half untouched", int'(mem[5]), int'(exp_max[5]));

        // R10: split scan over one full period
        lo = 0; hi = 0;
        prev = disp_addr;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk(disp_addr == prev + 1'b1, "R10 scan consecutive", int'(disp_addr), int'(prev + 1'b1));
            if (scan_half) begin
                lo++;
                chk(disp_addr < AW'(HALF), "R10 stored half range", int'(disp_addr), 0);
            end else begin
                hi++;
                chk(disp_addr >= AW'(HALF), "R10 refresh half range", int'(disp_addr), HALF);
            end
            prev = disp_addr;
        end
        chk(lo == HALF && hi == HALF, "R10 half lengths", lo, HALF);

        // equal pairs: compare carry never set (R4)
        bd_fill(0);
        run_store(1'b0);
        // 0/255 extremes in both orders (R4, R5)
        bd_fill(1);
        run_store(1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule